// File: doc/BRIEF.md
# Stimulus and Entropy Pool Sequencer

This block runs the sampling phase of one round of a hardware random bit source. A start pulse begins a fixed run of 261 steps. In each step the block closes a sample switch, then drives a charge or discharge control for a set number of clock cycles, then opens the switch and asks an external converter for one conversion. Of each result it keeps only the least significant bit.

The stimulus for each step comes from a fixed opening pattern for the first five steps. After that, each stimulus is one residual bit from the round engine XORed with the result bit from the step before. The block loads a 248-bit pool value when it starts. It folds the result bits of steps 14 through 261 into that pool, one bit per step. It then pulses done so that the round engine can take the updated pool.

Top module: `entropy_sampler`

## Requirements
- R1: After reset `switch_o`, `charge_o`, `discharge_o`, `conv_start_o`, `busy_o` and `done_o` are low and `pool_o` is all zeros.
- R2: An accepted start runs exactly 261 steps. Each step gives one single-cycle `conv_start_o` pulse. `done_o` is high for exactly one cycle, in the cycle after the step-261 result is taken, and `busy_o` is low in that cycle.
- R3: The stimulus of steps 1 to 5 is 1,0,1,0,1. A stimulus of 1 drives `charge_o` and a stimulus of 0 drives `discharge_o`.
- R4: For step i from 6 to 261 the stimulus is residual bit r(i-5) XOR the result bit captured at step i-1. Residual bit r(k) is `residual_i[k-1]`.
- R5: Only `conv_data_i[0]` is kept, and it is sampled in the cycle where `conv_done_i` is high while a result is awaited. The upper result bits have no effect on the pool or on the stimulus.
- R6: At an accepted start, `pool_o` is loaded from `pool_seed_i`. When step i (14 to 261) completes, `pool_o[i-14]` is XORed with that step's result bit. The results of steps 1 to 13 never reach the pool.
- R7: `charge_o` and `discharge_o` are never high together, and neither is high while `switch_o` is low.
- R8: Within a step, `switch_o` is high for one cycle before the drive starts. The drive lasts exactly DRIVE_CYC cycles. In the cycle after the drive, `switch_o` is low and `conv_start_o` is high.
- R9: A start is accepted only while idle. `residual_i` and `pool_seed_i` are captured at the accepted start. Start pulses and input changes during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a round of sampling (idle only) |
| residual_i | input | 256 | Residual bits from the round engine, bit k-1 holds r(k) |
| pool_seed_i | input | 248 | Pool value loaded at start |
| conv_done_i | input | 1 | Converter result valid |
| conv_data_i | input | ADC_W | Converter result, only bit 0 used |
| switch_o | output | 1 | Sample switch closed |
| charge_o | output | 1 | Charge drive active |
| discharge_o | output | 1 | Discharge drive active |
| conv_start_o | output | 1 | One-cycle conversion request |
| busy_o | output | 1 | Round in progress |
| done_o | output | 1 | One-cycle pulse at the end of the round |
| pool_o | output | 248 | Pool register |

## Verification
The bench uses a converter model whose result bits it chooses, with random upper bits and a latency that varies. It rebuilds the expected stimulus sequence and the final pool from the requirements. An off-by-one in the feedback index would scramble every stimulus from step 6 on. A wrong fold offset would shift the pool, or would let the results of steps 1 to 13 leak into it. Using a wider result field would make the pool depend on the random upper bits. A run that restarts on a second start, or that reads the live residual inputs instead of the captured copy, would change the stimulus sequence or the step count. A drive that is one cycle too short or too long, or an overlap of charge and discharge, is caught by a per-cycle monitor.

// File: rtl/sampler_pkg.sv
package sampler_pkg;

    localparam int N_STEPS    = 261;
    localparam int PRE_LEN    = 5;
    localparam int RES_W      = 256;
    localparam int POOL_W     = 248;
    localparam int FOLD_FIRST = N_STEPS - POOL_W + 1;
    localparam int STEP_W     = $clog2(N_STEPS + 1);
    localparam int RIDX_W     = $clog2(RES_W);
    localparam int PIDX_W     = $clog2(POOL_W);

    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_DRIVE,
        PH_CONV,
        PH_WAIT
    } phase_e;

    typedef struct packed {
        logic sw;
        logic chg;
        logic dis;
        logic conv;
    } ctl_s;

    // opening pattern 1,0,1,0,1 follows the step parity
    function automatic logic opening_bit(step_t s);
        return s[0];
    endfunction

endpackage

// File: rtl/sampler_timer.sv
module sampler_timer #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic last_o
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last_o = run && (cnt == CW'(CYC - 1));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < CW'(CYC)));  // R8

endmodule

// File: rtl/sampler_stim.sv
module sampler_stim
    import sampler_pkg::*;
(
    input  step_t            step,
    input  logic [RES_W-1:0] residual,
    input  logic             prev_lsb,
    output logic             stim_o
);
    logic [RIDX_W-1:0] ridx;

    assign ridx = RIDX_W'(step - step_t'(PRE_LEN + 1));

    always_comb begin
        if (step <= step_t'(PRE_LEN)) begin
            stim_o = opening_bit(step);
        end else begin
            stim_o = residual[ridx] ^ prev_lsb;
        end
    end

endmodule

// File: rtl/sampler_pool.sv
module sampler_pool
    import sampler_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [POOL_W-1:0] seed,
    input  logic              fold_en,
    input  step_t             step,
    input  logic              lsb,
    output logic [POOL_W-1:0] pool_o
);
    logic              in_window;
    logic [PIDX_W-1:0] pidx;

    assign in_window = (step >= step_t'(FOLD_FIRST)) && (step <= step_t'(N_STEPS));
    assign pidx      = PIDX_W'(step - step_t'(FOLD_FIRST));

    for (genvar i = 0; i < POOL_W; i++) begin : g_bit
        logic hit;
        assign hit = fold_en && in_window && (pidx == PIDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                pool_o[i] <= 1'b0;
            end else if (load) begin
                pool_o[i] <= seed[i];
            end else if (hit) begin
                pool_o[i] <= pool_o[i] ^ lsb;
            end
        end
    end

    AST_EARLY_NO_FOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && fold_en && step < step_t'(FOLD_FIRST)) |=> $stable(pool_o));  // R6

endmodule

// File: rtl/entropy_sampler.sv
module entropy_sampler
    import sampler_pkg::*;
#(
    parameter int DRIVE_CYC = 8,
    parameter int ADC_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [RES_W-1:0]  residual_i,
    input  logic [POOL_W-1:0] pool_seed_i,
    input  logic              conv_done_i,
    input  logic [ADC_W-1:0]  conv_data_i,
    output logic              switch_o,
    output logic              charge_o,
    output logic              discharge_o,
    output logic              conv_start_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [POOL_W-1:0] pool_o
);
    localparam step_t LAST_STEP = step_t'(N_STEPS);

    phase_e           phase;
    step_t            step;
    logic             prev_lsb;
    logic             done_q;
    logic [RES_W-1:0] res_q;
    logic             stim;
    logic             t_last;
    logic             accept;
    logic             take;
    ctl_s             ctl;
    logic             unused_conv_hi;

    assign unused_conv_hi = ^conv_data_i;
    assign accept = (phase == PH_IDLE) && start_i;
    assign take   = (phase == PH_WAIT) && conv_done_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            step     <= '0;
            prev_lsb <= 1'b0;
            done_q   <= 1'b0;
            res_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start_i) begin
                        res_q    <= residual_i;
                        step     <= step_t'(1);
                        prev_lsb <= 1'b0;
                        phase    <= PH_SETTLE;
                    end
                end
                PH_SETTLE: phase <= PH_DRIVE;
                PH_DRIVE:  if (t_last) phase <= PH_CONV;
                PH_CONV:   phase <= PH_WAIT;
                PH_WAIT: begin
                    if (conv_done_i) begin
                        prev_lsb <= conv_data_i[0];
                        if (step == LAST_STEP) begin
                            phase  <= PH_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            step  <= step + 1'b1;
                            phase <= PH_SETTLE;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    sampler_timer #(.CYC(DRIVE_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (phase == PH_SETTLE),
        .run    (phase == PH_DRIVE),
        .last_o (t_last)
    );

    sampler_stim u_stim (
        .step     (step),
        .residual (res_q),
        .prev_lsb (prev_lsb),
        .stim_o   (stim)
    );

    sampler_pool u_pool (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .seed    (pool_seed_i),
        .fold_en (take),
        .step    (step),
        .lsb     (conv_data_i[0]),
        .pool_o  (pool_o)
    );

    always_comb begin
        ctl = '0;
        unique case (phase)
            PH_SETTLE: ctl.sw = 1'b1;
            PH_DRIVE: begin
                ctl.sw  = 1'b1;
                ctl.chg = stim;
                ctl.dis = !stim;
            end
            PH_CONV: ctl.conv = 1'b1;
            default: ctl = '0;
        endcase
    end

    assign switch_o     = ctl.sw;
    assign charge_o     = ctl.chg;
    assign discharge_o  = ctl.dis;
    assign conv_start_o = ctl.conv;
    assign busy_o       = (phase != PH_IDLE);
    assign done_o       = done_q;

    AST_DRIVE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(charge_o && discharge_o));  // R7
    AST_DRIVE_SWITCH: assert property (@(posedge clk) disable iff (rst)
        (charge_o || discharge_o) |-> switch_o);  // R7
    AST_CONV_OPEN: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |-> !switch_o);  // R8
    AST_CONV_SINGLE: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |=> !conv_start_o);  // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);  // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);  // R2
    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        step <= LAST_STEP);  // R2
    AST_OPENING: assert property (@(posedge clk) disable iff (rst)
        ((charge_o || discharge_o) && step <= step_t'(PRE_LEN)) |-> (charge_o == step[0]));  // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !take && start_i) |=> (step == $past(step)));  // R9

endmodule

// File: tb/entropy_sampler_tb.sv
module entropy_sampler_tb;
    import sampler_pkg::*;

    localparam int DRIVE = 8;
    localparam int ADC_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              start_i;
    logic [RES_W-1:0]  residual_i;
    logic [POOL_W-1:0] pool_seed_i;
    logic              conv_done_i;
    logic [ADC_W-1:0]  conv_data_i;
    logic              switch_o, charge_o, discharge_o, conv_start_o, busy_o, done_o;
    logic [POOL_W-1:0] pool_o;

    always #4 clk = ~clk;

    entropy_sampler #(.DRIVE_CYC(DRIVE), .ADC_W(ADC_W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .residual_i(residual_i),
        .pool_seed_i(pool_seed_i), .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
        .switch_o(switch_o), .charge_o(charge_o), .discharge_o(discharge_o),
        .conv_start_o(conv_start_o), .busy_o(busy_o), .done_o(done_o), .pool_o(pool_o)
    );

    int   checks = 0;
    int   errors = 0;
    int   conv_cnt, lat, run_len, done_hi;
    int   viol_excl, viol_sw, viol_len;
    logic d_bits   [0:N_STEPS+1];
    logic stim_seen[0:N_STEPS+1];
    logic prev_drv, prev_sw;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle monitor of the drive outputs
    always @(negedge clk) begin
        if (!rst) begin
            if (charge_o && discharge_o) viol_excl++;
            if ((charge_o || discharge_o) && !switch_o) viol_sw++;
            if ((charge_o || discharge_o) && !prev_drv) begin
                if (conv_cnt + 1 <= N_STEPS) stim_seen[conv_cnt+1] = charge_o;
                if (!prev_sw) viol_sw++;
                run_len = 1;
            end else if (charge_o || discharge_o) begin
                run_len++;
            end
            if (!(charge_o || discharge_o) && prev_drv && run_len != DRIVE) viol_len++;
            if (conv_start_o && switch_o) viol_sw++;
            if (conv_start_o) conv_cnt++;
            if (done_o) done_hi++;
            prev_drv = charge_o || discharge_o;
            prev_sw  = switch_o;
        end
    end

    // converter model
    initial begin
        conv_done_i = 1'b0;
        conv_data_i = '0;
        forever begin
            @(negedge clk);
            if (conv_start_o) begin
                repeat (lat) @(negedge clk);
                conv_data_i = {7'($urandom), d_bits[conv_cnt]};
                conv_done_i = 1'b1;
                @(negedge clk);
                conv_done_i = 1'b0;
                conv_data_i = ADC_W'($urandom);
            end
        end
    end

    task automatic run_round(input logic [RES_W-1:0] res, input logic [POOL_W-1:0] seed,
                             input int mode, input int latency, input bit disturb);
        logic [POOL_W-1:0] exp_pool;
        int t, bad_pre, bad_fb;
        for (int i = 0; i <= N_STEPS + 1; i++) begin
            d_bits[i] = (mode == 0) ? 1'b0 : (mode == 1) ? 1'b1 : 1'($urandom);
            stim_seen[i] = 1'bx;
        end
        conv_cnt = 0; done_hi = 0; viol_excl = 0; viol_sw = 0; viol_len = 0;
        lat = latency;
        residual_i = res;
        pool_seed_i = seed;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        if (disturb) begin
            repeat (60) @(negedge clk);
            residual_i  = ~res;
            pool_seed_i = ~seed;
            start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
            repeat (300) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
        end
        t = 0;
        while (!done_o && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 20000, "R2", "round reached done", 256'(t), 256'(0));
        chk(!busy_o, "R2", "busy low with done", 256'(busy_o), 256'(0));
        exp_pool = seed;
        for (int i = 1; i <= POOL_W; i++) exp_pool[i-1] ^= d_bits[i+13];
        chk(pool_o === exp_pool, "R6", "pool after round (R5 LSB only, R9 captured seed)",
            256'(pool_o), 256'(exp_pool));
        @(negedge clk);
        chk(!done_o && done_hi == 1, "R2", "done single cycle", 256'(done_hi), 256'(1));
        chk(conv_cnt == N_STEPS, "R2", "conversion count", 256'(conv_cnt), 256'(N_STEPS));
        bad_pre = 0; bad_fb = 0;
        for (int i = 1; i <= N_STEPS; i++) begin
            logic e;
            e = (i <= PRE_LEN) ? 1'(i % 2) : (res[i-6] ^ d_bits[i-1]);
            if (stim_seen[i] !== e) begin
                if (i <= PRE_LEN) bad_pre++; else bad_fb++;
            end
        end
        chk(bad_pre == 0, "R3", "opening stimulus mismatches", 256'(bad_pre), 256'(0));
        chk(bad_fb == 0, "R4", "feedback stimulus mismatches (R9 captured residual)",
            256'(bad_fb), 256'(0));
        chk(viol_excl == 0 && viol_sw == 0, "R7", "drive exclusivity/switch",
            256'(viol_excl + viol_sw), 256'(0));
        chk(viol_len == 0, "R8", "drive length", 256'(viol_len), 256'(0));
    endtask

    task automatic test_reset();
        chk(!switch_o && !charge_o && !discharge_o && !conv_start_o && !busy_o && !done_o,
            "R1", "control outputs after reset",
            256'({switch_o, charge_o, discharge_o, conv_start_o, busy_o, done_o}), 256'(0));
        chk(pool_o == '0, "R1", "pool after reset", 256'(pool_o), 256'(0));
    endtask

    task automatic test_zero_stream();
        run_round('0, '0, 0, 1, 1'b0);
    endtask

    task automatic test_random_stream();
        run_round({8{32'($urandom)}}, {8{31'($urandom)}}, 2, 3, 1'b0);
    endtask

    task automatic test_ones_stream();
        run_round({8{32'hA5C3_0F96}}, {31{8'h5A}}, 1, 2, 1'b0);
    endtask

    task automatic test_busy_start();
        run_round({8{32'($urandom)}}, {8{31'($urandom)}}, 2, 1, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; residual_i = '0; pool_seed_i = '0;
        lat = 1; conv_cnt = 0; run_len = 0; done_hi = 0;
        viol_excl = 0; viol_sw = 0; viol_len = 0; prev_drv = 1'b0; prev_sw = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_zero_stream();
        test_random_stream();
        test_ones_stream();
        test_busy_start();
        test_random_stream();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule